// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block turns an asynchronous serial line into parallel words. A programmable prescaler makes the sampling tick. Each bit time is sixteen ticks, so the line rate is the clock frequency divided by sixteen times (prescale + 1). A falling edge on the idle line starts a character. The start bit is confirmed half a bit later. After that, one sample is taken per bit time in the middle of the bit, least significant bit first.

The word length can be set from five to nine bits. Parity can be off, odd, even, forced low or forced high. One or two stop bits can be selected. Each finished word goes out on a one-cycle push towards an external FIFO write port. Status pulses come out at the same time: a parity error, a framing error, an overrun when the FIFO is full, and a match when the word equals a programmed value. A separate pulse marks the end of a programmed number of idle bit times after the last character. Software can use it to drain a short message that never fills the FIFO.

The line first passes a loopback selector, which can take the local transmitter's output instead of the pin. It then goes through a two-stage synchronizer and an optional glitch filter. The FIFO storage, the register file and interrupt handling sit outside this block.

Top module: `uart_rx_core`

## Requirements
- R1: With a prescale value P, one bit time is 16·(P+1) clock cycles. Characters sent at that rate are received correctly for every P tested.
- R2: The word length is taken from `data_bits`, which is clamped to the range 5..9. Bits arrive least significant first. The word is presented on `fifo_data` zero-extended to 9 bits.
- R3: `parity_mode` encoding: 3'b000 none, 3'b001 odd, 3'b010 even, 3'b100 parity bit expected 0, 3'b101 parity bit expected 1. The other codes behave as none. A received parity bit that differs from the expected one pulses `parity_err` together with the word's push or overrun.
- R4: `two_stop` = 0 selects one stop bit and 1 selects two. A low sample at any expected stop bit pulses `frame_err`. The word is still delivered.
- R5: A start is accepted only if the line is still low 8 ticks after the falling edge. A shorter low pulse produces no word.
- R6: When a word completes while `fifo_full` is high, `fifo_push` stays low and `overrun` pulses instead.
- R7: `match_evt` pulses with a completed word whose value equals the low `data_bits` bits of `match_value`.
- R8: `timeout_evt` pulses once after the line has stayed idle for `timeout_bits` bit times following the end of a word. A new start cancels the pending pulse, and a value of 0 disables it.
- R9: With `filter_en` = 1, a new line level is taken only after it has held for 3 consecutive clock cycles. Pulses of 2 cycles never reach the receiver.
- R10: With `loopback_en` = 1, the receiver takes `tx_loop` and ignores `rx_pin`.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_pin | input | 1 | Serial line from the pin |
| tx_loop | input | 1 | Local transmitter output, used in loopback |
| loopback_en | input | 1 | Select `tx_loop` as the receive line |
| filter_en | input | 1 | Enable the 3-cycle glitch filter |
| prescale | input | 16 | Tick divider; one tick every prescale+1 clocks |
| data_bits | input | 4 | Word length, clamped to 5..9 |
| parity_mode | input | 3 | Parity mode, encoded as in R3 |
| two_stop | input | 1 | 1 = two stop bits |
| timeout_bits | input | 6 | Idle bit times before `timeout_evt`; 0 disables |
| match_value | input | 9 | Comparison value for `match_evt` |
| fifo_full | input | 1 | External FIFO cannot accept a word |
| fifo_push | output | 1 | One-cycle write strobe for `fifo_data` |
| fifo_data | output | 9 | Received word, zero-extended |
| parity_err | output | 1 | Parity mismatch on the completed word |
| frame_err | output | 1 | Stop bit sampled low on the completed word |
| overrun | output | 1 | Word completed while the FIFO was full |
| timeout_evt | output | 1 | Idle timeout pulse |
| match_evt | output | 1 | Completed word equals the match value |

## Verification
The assertions assume that the configuration inputs stay unchanged while a character is in flight. The stop-bit and parity checks also assume that a word cannot complete on two cycles in a row, which holds because every character lasts at least 96 clock cycles. The bench only changes configuration while the line idles between characters. It drives each bit for exactly 16·(P+1) cycles and adds glitches only as 2-cycle inversions that leave at least 3 stable cycles around each one.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int WORD_W   = 9;
    localparam int MIN_BITS = 5;
    localparam int OVERSAMP = 16;
    localparam int CNT_W    = $clog2(OVERSAMP);
    localparam int MID_TICK = OVERSAMP / 2 - 1;

    typedef enum logic [2:0] {
        PAR_NONE = 3'b000,
        PAR_ODD  = 3'b001,
        PAR_EVEN = 3'b010,
        PAR_ZERO = 3'b100,
        PAR_ONE  = 3'b101
    } parity_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP1, ST_STOP2
    } rx_state_e;

    typedef struct packed {
        logic [3:0] nbits;
        logic [2:0] pmode;
        logic       two_stop;
    } rx_cfg_t;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              par_err;
        logic              frm_err;
    } rx_word_t;

    function automatic logic [3:0] clamp_bits(input logic [3:0] n);
        if (n < 4'(MIN_BITS)) return 4'(MIN_BITS);
        if (n > 4'(WORD_W))   return 4'(WORD_W);
        return n;
    endfunction

    function automatic logic [WORD_W-1:0] width_mask(input logic [3:0] n);
        logic [WORD_W:0] t;
        t = ({{WORD_W{1'b0}}, 1'b1} << n) - 1'b1;
        return t[WORD_W-1:0];
    endfunction

    function automatic logic uses_parity(input logic [2:0] m);
        return m == PAR_ODD || m == PAR_EVEN || m == PAR_ZERO || m == PAR_ONE;
    endfunction

    function automatic logic parity_bit(input logic [2:0] m, input logic [WORD_W-1:0] d);
        case (m)
            PAR_ODD:  return ~(^d);
            PAR_EVEN: return ^d;
            PAR_ONE:  return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
    parameter int PRESCALE_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PRESCALE_W-1:0] prescale,
    output logic                  tick
);
    logic [PRESCALE_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= prescale) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_rx_deglitch.sv
module uart_rx_deglitch #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic din,
    output logic dout
);
    logic [FILT_LEN-1:0] hist;
    logic                held;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '1;
            held <= 1'b1;
        end else begin
            hist <= {hist[FILT_LEN-2:0], din};
            if (hist == '1)      held <= 1'b1;
            else if (hist == '0) held <= 1'b0;
        end
    end

    assign dout = enable ? held : din;
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
    import uart_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     line,
    input  rx_cfg_t  cfg,
    output logic     start_seen,
    output logic     done,
    output rx_word_t word
);
    rx_state_e         st;
    logic [CNT_W-1:0]  cnt;
    logic [3:0]        idx;
    logic [WORD_W-1:0] shreg;
    logic              prev, perr, ferr;
    logic              at_mid;

    assign at_mid = (cnt == CNT_W'(OVERSAMP - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE; cnt <= '0; idx <= '0; shreg <= '0;
            prev <= 1'b1; perr <= 1'b0; ferr <= 1'b0;
            start_seen <= 1'b0; done <= 1'b0; word <= '0;
        end else begin
            start_seen <= 1'b0;
            done       <= 1'b0;
            if (tick) begin
                prev <= line;
                if (st != ST_IDLE && st != ST_START) cnt <= at_mid ? '0 : cnt + 1'b1;
                case (st)
                    ST_IDLE: if (!line && prev) begin
                        st <= ST_START; cnt <= '0; start_seen <= 1'b1;
                    end
                    ST_START: if (cnt == CNT_W'(MID_TICK)) begin
                        cnt <= '0;
                        if (!line) begin
                            st <= ST_DATA; idx <= '0; shreg <= '0;
                            perr <= 1'b0; ferr <= 1'b0;
                        end else st <= ST_IDLE;
                    end else cnt <= cnt + 1'b1;
                    ST_DATA: if (at_mid) begin
                        shreg[idx] <= line;
                        if (idx == cfg.nbits - 4'd1)
                            st <= uses_parity(cfg.pmode) ? ST_PARITY : ST_STOP1;
                        else idx <= idx + 4'd1;
                    end
                    ST_PARITY: if (at_mid) begin
                        perr <= (line != parity_bit(cfg.pmode, shreg));
                        st   <= ST_STOP1;
                    end
                    ST_STOP1: if (at_mid) begin
                        if (cfg.two_stop) begin
                            ferr <= ferr | !line;
                            st   <= ST_STOP2;
                        end else begin
                            st <= ST_IDLE; done <= 1'b1;
                            word <= '{data: shreg, par_err: perr, frm_err: ferr | !line};
                        end
                    end
                    ST_STOP2: if (at_mid) begin
                        st <= ST_IDLE; done <= 1'b1;
                        word <= '{data: shreg, par_err: perr, frm_err: ferr | !line};
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_rx_idle_timer.sv
module uart_rx_idle_timer
    import uart_rx_pkg::*;
#(
    parameter int TIMEOUT_W = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 arm,
    input  logic                 clear,
    input  logic [TIMEOUT_W-1:0] limit,
    output logic                 fire
);
    logic                 armed;
    logic [CNT_W-1:0]     sub;
    logic [TIMEOUT_W-1:0] bits;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            armed <= 1'b0; sub <= '0; bits <= '0; fire <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (arm) begin
                armed <= (limit != '0); sub <= '0; bits <= '0;
            end else if (armed && tick) begin
                if (sub == CNT_W'(OVERSAMP - 1)) begin
                    sub <= '0;
                    if (bits == limit - 1'b1) begin
                        fire <= 1'b1; armed <= 1'b0;
                    end else bits <= bits + 1'b1;
                end else sub <= sub + 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int PRESCALE_W  = 16,
    parameter int TIMEOUT_W   = 6,
    parameter int FILT_LEN    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rx_pin,
    input  logic                  tx_loop,
    input  logic                  loopback_en,
    input  logic                  filter_en,
    input  logic [PRESCALE_W-1:0] prescale,
    input  logic [3:0]            data_bits,
    input  logic [2:0]            parity_mode,
    input  logic                  two_stop,
    input  logic [TIMEOUT_W-1:0]  timeout_bits,
    input  logic [WORD_W-1:0]     match_value,
    input  logic                  fifo_full,
    output logic                  fifo_push,
    output logic [WORD_W-1:0]     fifo_data,
    output logic                  parity_err,
    output logic                  frame_err,
    output logic                  overrun,
    output logic                  timeout_evt,
    output logic                  match_evt
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   line, tick, start_seen, done;
    rx_word_t               word;
    rx_cfg_t                cfg;

    assign cfg = '{nbits: clamp_bits(data_bits), pmode: parity_mode, two_stop: two_stop};

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], loopback_en ? tx_loop : rx_pin};
    end

    uart_rx_deglitch #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk(clk), .rst(rst), .enable(filter_en),
        .din(sync_q[SYNC_STAGES-1]), .dout(line)
    );

    uart_rx_tick #(.PRESCALE_W(PRESCALE_W)) u_tick (
        .clk(clk), .rst(rst), .prescale(prescale), .tick(tick)
    );

    uart_rx_framer u_frame (
        .clk(clk), .rst(rst), .tick(tick), .line(line), .cfg(cfg),
        .start_seen(start_seen), .done(done), .word(word)
    );

    uart_rx_idle_timer #(.TIMEOUT_W(TIMEOUT_W)) u_idle (
        .clk(clk), .rst(rst), .tick(tick), .arm(done), .clear(start_seen),
        .limit(timeout_bits), .fire(timeout_evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_push <= 1'b0; fifo_data <= '0; parity_err <= 1'b0;
            frame_err <= 1'b0; overrun <= 1'b0; match_evt <= 1'b0;
        end else begin
            fifo_push  <= done && !fifo_full;
            overrun    <= done && fifo_full;
            parity_err <= done && word.par_err;
            frame_err  <= done && word.frm_err;
            match_evt  <= done && (word.data == (match_value & width_mask(cfg.nbits)));
            if (done) fifo_data <= word.data;
        end
    end
endmodule

// File: rtl/uart_rx_core_checker.sv
module uart_rx_core_checker
    import uart_rx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [3:0]        data_bits,
    input logic [2:0]        parity_mode,
    input logic              fifo_full,
    input logic              fifo_push,
    input logic [WORD_W-1:0] fifo_data,
    input logic              parity_err,
    input logic              frame_err,
    input logic              overrun,
    input logic              timeout_evt,
    input logic              match_evt
);
    AST_PUSH_OR_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        !(fifo_push && overrun)); // R6
    AST_FULL_BLOCKS_PUSH: assert property (@(posedge clk) disable iff (rst)
        fifo_push |-> !$past(fifo_full)); // R6
    AST_PARITY_NEEDS_WORD: assert property (@(posedge clk) disable iff (rst)
        parity_err |-> (fifo_push || overrun)); // R3
    AST_PARITY_MODE_ON: assert property (@(posedge clk) disable iff (rst)
        parity_err |-> uses_parity($past(parity_mode))); // R3
    AST_FRAME_NEEDS_WORD: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> (fifo_push || overrun)); // R4
    AST_MATCH_NEEDS_WORD: assert property (@(posedge clk) disable iff (rst)
        match_evt |-> (fifo_push || overrun)); // R7
    AST_WORD_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
        fifo_push |-> ((fifo_data & ~width_mask(clamp_bits($past(data_bits)))) == '0)); // R2
    AST_PUSH_SPACING: assert property (@(posedge clk) disable iff (rst)
        fifo_push |=> !fifo_push); // R1
    AST_TIMEOUT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        timeout_evt |=> !timeout_evt); // R8
    AST_TIMEOUT_APART: assert property (@(posedge clk) disable iff (rst)
        timeout_evt |-> !fifo_push); // R8
endmodule

bind uart_rx_core uart_rx_core_checker u_chk (.*);

// File: tb/uart_rx_core_test.sv
`timescale 1ns/1ps
module uart_rx_core_test;
    logic clk = 1'b0, rst = 1'b1;
    logic rx_pin = 1'b1, tx_loop = 1'b1, loopback_en = 1'b0, filter_en = 1'b0;
    logic [15:0] prescale = 16'd1;
    logic [3:0]  data_bits = 4'd8;
    logic [2:0]  parity_mode = 3'b000;
    logic        two_stop = 1'b0;
    logic [5:0]  timeout_bits = 6'd0;
    logic [8:0]  match_value = 9'h1FF;
    logic        fifo_full = 1'b0;
    logic        fifo_push, parity_err, frame_err, overrun, timeout_evt, match_evt;
    logic [8:0]  fifo_data;

    int checks = 0, errors = 0;
    int push_cnt = 0, ovr_cnt = 0, to_cnt = 0, match_cnt = 0, perr_cnt = 0, ferr_cnt = 0;
    logic [8:0] last_data = '0;
    logic last_perr = 1'b0, last_ferr = 1'b0;
    bit lb_mode = 1'b0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    uart_rx_core uut (.*);

    always @(negedge clk) begin
        if (!rst) begin
            if (fifo_push) begin
                push_cnt++; last_data = fifo_data;
                last_perr = parity_err; last_ferr = frame_err;
            end
            if (overrun) begin
                ovr_cnt++; last_data = fifo_data; last_perr = parity_err; last_ferr = frame_err;
            end
            if (timeout_evt) to_cnt++;
            if (match_evt)   match_cnt++;
            if (parity_err)  perr_cnt++;
            if (frame_err)   ferr_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic model_par(input logic [2:0] m, input logic [8:0] d);
        case (m)
            3'b001:  return ~(^d);
            3'b010:  return ^d;
            3'b101:  return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit model_has_par(input logic [2:0] m);
        return m == 3'b001 || m == 3'b010 || m == 3'b100 || m == 3'b101;
    endfunction

    function automatic logic [8:0] model_mask(input int w);
        return 9'((10'd1 << w) - 10'd1);
    endfunction

    task automatic set_line(input logic v);
        if (lb_mode) tx_loop = v; else rx_pin = v;
    endtask

    task automatic drive_bit(input logic v, input bit glitch);
        int bp = (int'(prescale) + 1) * 16;
        for (int k = 0; k < bp; k++) begin
            @(negedge clk);
            set_line((glitch && (k % 8 == 3 || k % 8 == 4)) ? ~v : v);
        end
    endtask

    task automatic send_frame(input logic [8:0] d, input int w, input bit flip,
                              input logic s1, input logic s2, input int gap, input bit glitch);
        logic [8:0] dm = d & model_mask(w);
        drive_bit(1'b0, glitch);
        for (int i = 0; i < w; i++) drive_bit(dm[i], glitch);
        if (model_has_par(parity_mode)) drive_bit(model_par(parity_mode, dm) ^ flip, glitch);
        drive_bit(s1, glitch);
        if (two_stop) drive_bit(s2, glitch);
        for (int g = 0; g < gap; g++) drive_bit(1'b1, 1'b0);
    endtask

    initial begin
        #5_000_000;
        if (!done_flag) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int p0, w, exp_w;
        logic [8:0] d;
        logic [2:0] pm_tab [5] = '{3'b000, 3'b001, 3'b010, 3'b100, 3'b101};
        void'($urandom(32'd20250112));
        repeat (4) @(negedge clk);
        check({fifo_push, parity_err, frame_err, overrun, timeout_evt, match_evt} == 0,
              "R11 reset outputs", 0, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1: fastest prescale, 8N1
        prescale = 16'd0; p0 = push_cnt;
        send_frame(9'h0A5, 8, 0, 1, 1, 2, 0);
        check(push_cnt == p0 + 1 && last_data == 9'h0A5, "R1 prescale 0", last_data, 9'h0A5);
        prescale = 16'd3; p0 = push_cnt;
        send_frame(9'h03C, 8, 0, 1, 1, 2, 0);
        check(push_cnt == p0 + 1 && last_data == 9'h03C, "R1 prescale 3", last_data, 9'h03C);
        prescale = 16'd1;

        // R2: extremes and clamping
        data_bits = 4'd5; send_frame(9'h1FF, 5, 0, 1, 1, 2, 0);
        check(last_data == 9'h01F, "R2 five bits", last_data, 9'h01F);
        data_bits = 4'd9; send_frame(9'h155, 9, 0, 1, 1, 2, 0);
        check(last_data == 9'h155, "R2 nine bits", last_data, 9'h155);
        data_bits = 4'd3; send_frame(9'h016, 5, 0, 1, 1, 2, 0);
        check(last_data == 9'h016, "R2 clamp low to 5", last_data, 9'h016);
        data_bits = 4'd12; send_frame(9'h1A3, 9, 0, 1, 1, 2, 0);
        check(last_data == 9'h1A3, "R2 clamp high to 9", last_data, 9'h1A3);
        data_bits = 4'd8;

        // R3: each parity mode, good and flipped
        for (int m = 1; m < 5; m++) begin
            parity_mode = pm_tab[m];
            p0 = perr_cnt;
            send_frame(9'h06B, 8, 0, 1, 1, 2, 0);
            check(perr_cnt == p0 && last_data == 9'h06B, "R3 parity good", perr_cnt - p0, 0);
            send_frame(9'h06B, 8, 1, 1, 1, 2, 0);
            check(perr_cnt == p0 + 1 && last_perr, "R3 parity flipped", perr_cnt - p0, 1);
        end
        parity_mode = 3'b011; p0 = perr_cnt;
        send_frame(9'h011, 8, 0, 1, 1, 2, 0);
        check(perr_cnt == p0 && last_data == 9'h011, "R3 reserved code as none", last_data, 9'h011);
        parity_mode = 3'b000;

        // R4: framing errors on first and second stop bit
        p0 = ferr_cnt;
        send_frame(9'h042, 8, 0, 0, 1, 2, 0);
        check(ferr_cnt == p0 + 1 && last_data == 9'h042, "R4 stop low one stop", ferr_cnt - p0, 1);
        two_stop = 1'b1;
        send_frame(9'h024, 8, 0, 1, 0, 2, 0);
        check(ferr_cnt == p0 + 2 && last_data == 9'h024, "R4 second stop low", ferr_cnt - p0, 2);
        send_frame(9'h081, 8, 0, 1, 1, 2, 0);
        check(ferr_cnt == p0 + 2 && last_data == 9'h081, "R4 two good stops", ferr_cnt - p0, 2);
        two_stop = 1'b0;

        // R5: short low pulse is no start
        p0 = push_cnt;
        for (int k = 0; k < 10; k++) begin @(negedge clk); rx_pin = 1'b0; end
        @(negedge clk); rx_pin = 1'b1;
        repeat (32 * 14) @(negedge clk);
        check(push_cnt == p0, "R5 false start rejected", push_cnt - p0, 0);

        // R6: overrun
        fifo_full = 1'b1; p0 = push_cnt;
        send_frame(9'h0F0, 8, 0, 1, 1, 2, 0);
        check(push_cnt == p0 && ovr_cnt == 1, "R6 overrun when full", ovr_cnt, 1);
        fifo_full = 1'b0;

        // R7: match
        match_value = 9'h15A; data_bits = 4'd8; p0 = match_cnt;
        send_frame(9'h05A, 8, 0, 1, 1, 2, 0);
        check(match_cnt == p0 + 1, "R7 match low bits", match_cnt - p0, 1);
        send_frame(9'h05B, 8, 0, 1, 1, 2, 0);
        check(match_cnt == p0 + 1, "R7 no match", match_cnt - p0, 1);
        match_value = 9'h1FF;

        // R8: idle timeout
        timeout_bits = 6'd4; p0 = to_cnt;
        send_frame(9'h033, 8, 0, 1, 1, 1, 0);
        send_frame(9'h034, 8, 0, 1, 1, 1, 0);
        send_frame(9'h035, 8, 0, 1, 1, 1, 0);
        check(to_cnt == p0, "R8 no timeout between close frames", to_cnt - p0, 0);
        repeat (32 * 5) @(negedge clk);
        check(to_cnt == p0 + 1, "R8 timeout after idle", to_cnt - p0, 1);
        repeat (32 * 10) @(negedge clk);
        check(to_cnt == p0 + 1, "R8 timeout only once", to_cnt - p0, 1);
        timeout_bits = 6'd0;
        send_frame(9'h036, 8, 0, 1, 1, 10, 0);
        check(to_cnt == p0 + 1, "R8 zero disables", to_cnt - p0, 1);

        // R9: glitch filter
        filter_en = 1'b1; p0 = push_cnt;
        for (int k = 0; k < 32 * 12; k++) begin
            @(negedge clk); rx_pin = (k % 8 == 3 || k % 8 == 4) ? 1'b0 : 1'b1;
        end
        @(negedge clk); rx_pin = 1'b1;
        repeat (64) @(negedge clk);
        check(push_cnt == p0, "R9 idle glitches ignored", push_cnt - p0, 0);
        send_frame(9'h0C9, 8, 0, 1, 1, 2, 1);
        check(push_cnt == p0 + 1 && last_data == 9'h0C9, "R9 glitched frame", last_data, 9'h0C9);
        filter_en = 1'b0;

        // R10: loopback
        loopback_en = 1'b1; lb_mode = 1'b1; rx_pin = 1'b0; p0 = push_cnt;
        repeat (64) @(negedge clk);
        send_frame(9'h0D2, 8, 0, 1, 1, 2, 0);
        check(push_cnt == p0 + 1 && last_data == 9'h0D2, "R10 loopback source", last_data, 9'h0D2);
        rx_pin = 1'b1; repeat (64) @(negedge clk);
        loopback_en = 1'b0; lb_mode = 1'b0;
        repeat (64) @(negedge clk);

        // R1 R2 R3 R4: random configurations
        for (int n = 0; n < 24; n++) begin
            bit flip;
            prescale    = 16'($urandom_range(1, 3));
            w           = $urandom_range(5, 9);
            data_bits   = 4'(w);
            parity_mode = pm_tab[$urandom_range(0, 4)];
            two_stop    = 1'($urandom_range(0, 1));
            d           = 9'($urandom);
            flip        = model_has_par(parity_mode) && ($urandom_range(0, 3) == 0);
            exp_w       = w;
            p0 = push_cnt;
            send_frame(d, w, flip, 1, 1, 2, 0);
            check(push_cnt == p0 + 1 && last_data == (d & model_mask(exp_w)),
                  "R2 random word", last_data, d & model_mask(exp_w));
            check(last_perr == flip && !last_ferr, "R3 random parity flag", last_perr, flip);
        end

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule